// File: doc/BRIEF.md
# PATA PIO Register Access Engine

This block performs a single 16-bit programmed-I/O access on a parallel ATA cable. The host presents a start pulse along with a 4-bit device register number, a direction bit and a write word. The engine then steps through three timed phases. In the first, the chip selects and address lines become valid. In the second, the read or write strobe is asserted. In the third, the strobe is released and the cycle recovers. The host supplies the clock count for each phase on separate timing inputs.

On a read, the engine captures the cable data into a receive register. On either direction, it sets a sticky completion flag when the access finishes, and the host clears that flag by pulsing a clear input. When enabled, the device ready line can stretch the strobe phase. A multi-word data transfer is built by starting the engine again for each word. Each start moves exactly one word.

The controller has five states. `PH_IDLE` moves to `PH_SETUP` on an accepted start. `PH_SETUP` moves to `PH_STROBE` when the setup count is reached. `PH_STROBE` moves to `PH_HOLD` when the pulse count is met and the device is ready, provided the hold count is non-zero; otherwise it moves to `PH_RECOVER`. `PH_HOLD` moves to `PH_RECOVER` once the hold count has run out. Both `PH_HOLD` and `PH_RECOVER` return to `PH_IDLE` when the end count is reached, and that return raises done.

Top module: `pata_pio_engine`

## Requirements
- R1: After reset: busy and done are 0, the receive word is 0, both strobes are high, both chip selects are high, and output enable is 0.
- R2: While busy, register number bit 3 selects the chip select. With bit 3 = 0, `bus_cs_n_o` = 2'b10; with bit 3 = 1, `bus_cs_n_o` = 2'b01. `bus_addr_o` carries register bits 2:0. When idle, `bus_cs_n_o` = 2'b11 and `bus_addr_o` = 0.
- R3: The setup phase lasts max(`tim_setup_i`,1) cycles, with selects valid and both strobes high.
- R4: The strobe phase lasts max(`tim_pulse_i`,1) cycles. During it, only `bus_rd_n_o` is low on a read (`pio_wr_i`=0), and only `bus_wr_n_o` is low on a write (`pio_wr_i`=1).
- R5: When `rdy_en_i`=1, the strobe phase is extended for as long as `bus_rdy_i` is low at its final count. When `rdy_en_i`=0, `bus_rdy_i` has no effect.
- R6: After the strobe, the post phase lasts max(`tim_end_i`,`tim_hold_i`,1) cycles. On a write, output enable is high during setup, during the strobe, and during the first `tim_hold_i` post cycles, and it drives the write word. On a read, output enable stays 0.
- R7: On a read, `rdata_o` takes `bus_din_i` at the clock edge that ends the strobe phase. A write access leaves `rdata_o` unchanged.
- R8: `done_o` rises at the same edge at which `busy_o` falls. It stays at 1 when the next access starts.
- R9: A `done_clr_i` pulse clears `done_o`. If the clear arrives at the edge that completes an access, done remains 1.
- R10: A start while busy is ignored. The access in progress keeps its selects, direction and length.
- R11: `busy_o` rises the cycle after the start is accepted. It stays high for exactly the sum of the setup, strobe (including any stretch) and post phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pio_start_i | input | 1 | Start one access (accepted when idle) |
| pio_wr_i | input | 1 | 1 = write to device, 0 = read |
| pio_reg_i | input | 4 | Device register number |
| pio_wdata_i | input | 16 | Word to write |
| tim_setup_i | input | TIM_W | Address setup clocks |
| tim_pulse_i | input | TIM_W | Strobe width clocks |
| tim_end_i | input | TIM_W | Strobe release to end-of-cycle clocks |
| tim_hold_i | input | TIM_W | Write data hold clocks after strobe |
| rdy_en_i | input | 1 | Allow ready-line stretching |
| done_clr_i | input | 1 | Clear the done flag (write-one pulse) |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Sticky completion flag |
| rdata_o | output | 16 | Last read word |
| bus_cs_n_o | output | 2 | Chip selects, active low |
| bus_addr_o | output | 3 | Register address lines |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| bus_wr_n_o | output | 1 | Write strobe, active low |
| bus_dout_o | output | 16 | Data driven to the cable |
| bus_doe_o | output | 1 | Data output enable |
| bus_din_i | input | 16 | Data from the cable |
| bus_rdy_i | input | 1 | Device ready line |

## Verification
The hardest cases to provoke are the collisions with the edge that ends an access. One is a clear pulse landing on that edge; the other is a start arriving while the engine is busy. The bench runs a long access with done already set, then raises the clear during exactly the last counted cycle; a second access receives a conflicting start in its second cycle. Read data is made distinct in the strobe and post windows, so a sample taken one edge early or late gives the wrong word. The ready line is held low across the final strobe count both with stretching on and with it off.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

    localparam int REG_AW = 4;
    localparam int DATA_W = 16;
    localparam int BUS_AW = 3;
    localparam int CS_W   = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOVER
    } pio_phase_e;

    typedef struct packed {
        logic              wr;
        logic [REG_AW-1:0] reg_no;
        logic [DATA_W-1:0] wdata;
    } pio_cmd_t;

endpackage

// File: rtl/pata_pio_phase_cnt.sv
module pata_pio_phase_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // Saturating elapsed-cycle counter for the current phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pata_pio_addr_dec.sv
module pata_pio_addr_dec
    import pata_pio_pkg::*;
(
    input  logic              active_i,
    input  logic [REG_AW-1:0] reg_no_i,
    output logic [CS_W-1:0]   cs_n_o,
    output logic [BUS_AW-1:0] addr_o
);
    localparam int BLK_BIT = REG_AW - 1;

    // Bit 3 picks command block (select 0) or control block (select 1)
    always_comb begin
        cs_n_o = '1;
        addr_o = '0;
        if (active_i) begin
            addr_o = reg_no_i[BUS_AW-1:0];
            if (reg_no_i[BLK_BIT]) begin
                cs_n_o = 2'b01;
            end else begin
                cs_n_o = 2'b10;
            end
        end
    end

endmodule

// File: rtl/pata_pio_fsm.sv
module pata_pio_fsm
    import pata_pio_pkg::*;
#(
    parameter int TIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  pio_cmd_t         cmd_i,
    input  logic [TIM_W-1:0] t_setup_i,
    input  logic [TIM_W-1:0] t_pulse_i,
    input  logic [TIM_W-1:0] t_end_i,
    input  logic [TIM_W-1:0] t_hold_i,
    input  logic             rdy_en_i,
    input  logic             rdy_i,
    input  logic [TIM_W-1:0] cnt_i,
    output logic             cnt_clr_o,
    output logic             cnt_inc_o,
    output pio_phase_e       phase_o,
    output pio_cmd_t         cmd_o,
    output logic             sample_o,
    output logic             finish_o,
    output logic             active_o,
    output logic             rd_n_o,
    output logic             wr_n_o,
    output logic             doe_o
);
    localparam logic [TIM_W-1:0] ONE = {{(TIM_W-1){1'b0}}, 1'b1};

    pio_phase_e       phase_q, phase_d;
    pio_cmd_t         cmd_q;
    logic [TIM_W-1:0] len_setup, len_pulse, len_post;
    logic             setup_met, pulse_met, hold_met, post_met, dev_ready;

    // Phase lengths, each at least one cycle
    always_comb begin
        len_setup = (t_setup_i == '0) ? ONE : t_setup_i;
        len_pulse = (t_pulse_i == '0) ? ONE : t_pulse_i;
        len_post  = (t_end_i >= t_hold_i) ? t_end_i : t_hold_i;
        if (len_post == '0) begin
            len_post = ONE;
        end
    end

    assign setup_met = (cnt_i >= (len_setup - ONE));
    assign pulse_met = (cnt_i >= (len_pulse - ONE));
    assign hold_met  = (cnt_i >= (t_hold_i - ONE));
    assign post_met  = (cnt_i >= (len_post - ONE));
    assign dev_ready = !rdy_en_i || rdy_i;

    // Next state and phase-counter control
    always_comb begin
        phase_d   = phase_q;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        sample_o  = 1'b0;
        finish_o  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start_i) begin
                    phase_d   = PH_SETUP;
                    cnt_clr_o = 1'b1;
                end
            end
            PH_SETUP: begin
                if (setup_met) begin
                    phase_d   = PH_STROBE;
                    cnt_clr_o = 1'b1;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            PH_STROBE: begin
                if (pulse_met && dev_ready) begin
                    phase_d   = (t_hold_i != '0) ? PH_HOLD : PH_RECOVER;
                    cnt_clr_o = 1'b1;
                    sample_o  = !cmd_q.wr;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            PH_HOLD: begin
                if (post_met) begin
                    phase_d  = PH_IDLE;
                    finish_o = 1'b1;
                end else begin
                    cnt_inc_o = 1'b1;
                    if (hold_met) begin
                        phase_d = PH_RECOVER;
                    end
                end
            end
            PH_RECOVER: begin
                if (post_met) begin
                    phase_d  = PH_IDLE;
                    finish_o = 1'b1;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            default: begin
                phase_d = PH_IDLE;
            end
        endcase
    end

    // State register and command latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cmd_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if ((phase_q == PH_IDLE) && start_i) begin
                cmd_q <= cmd_i;
            end
        end
    end

    // Bus-side outputs decoded from the state
    always_comb begin
        active_o = (phase_q != PH_IDLE);
        rd_n_o   = !((phase_q == PH_STROBE) && !cmd_q.wr);
        wr_n_o   = !((phase_q == PH_STROBE) && cmd_q.wr);
        doe_o    = cmd_q.wr && ((phase_q == PH_SETUP) || (phase_q == PH_STROBE) ||
                                (phase_q == PH_HOLD));
    end

    assign phase_o = phase_q;
    assign cmd_o   = cmd_q;

    AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STROBE) |-> ($past(phase_q) != PH_IDLE)); // R3
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o)); // R4
    AST_RDY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_STROBE) && !rdy_en_i && pulse_met) |=> (phase_q != PH_STROBE)); // R5
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !doe_o); // R6

endmodule

// File: rtl/pata_pio_engine.sv
module pata_pio_engine
    import pata_pio_pkg::*;
#(
    parameter int TIM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pio_start_i,
    input  logic              pio_wr_i,
    input  logic [REG_AW-1:0] pio_reg_i,
    input  logic [DATA_W-1:0] pio_wdata_i,
    input  logic [TIM_W-1:0]  tim_setup_i,
    input  logic [TIM_W-1:0]  tim_pulse_i,
    input  logic [TIM_W-1:0]  tim_end_i,
    input  logic [TIM_W-1:0]  tim_hold_i,
    input  logic              rdy_en_i,
    input  logic              done_clr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [CS_W-1:0]   bus_cs_n_o,
    output logic [BUS_AW-1:0] bus_addr_o,
    output logic              bus_rd_n_o,
    output logic              bus_wr_n_o,
    output logic [DATA_W-1:0] bus_dout_o,
    output logic              bus_doe_o,
    input  logic [DATA_W-1:0] bus_din_i,
    input  logic              bus_rdy_i
);
    pio_cmd_t         cmd_in, cmd_cur;
    pio_phase_e       phase;
    logic [TIM_W-1:0] cnt;
    logic             cnt_clr, cnt_inc, sample, finish, active;
    logic             done_q;
    logic [DATA_W-1:0] rdata_q;

    assign cmd_in.wr     = pio_wr_i;
    assign cmd_in.reg_no = pio_reg_i;
    assign cmd_in.wdata  = pio_wdata_i;

    pata_pio_phase_cnt #(.W(TIM_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .cnt_o (cnt)
    );

    pata_pio_fsm #(.TIM_W(TIM_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (pio_start_i),
        .cmd_i     (cmd_in),
        .t_setup_i (tim_setup_i),
        .t_pulse_i (tim_pulse_i),
        .t_end_i   (tim_end_i),
        .t_hold_i  (tim_hold_i),
        .rdy_en_i  (rdy_en_i),
        .rdy_i     (bus_rdy_i),
        .cnt_i     (cnt),
        .cnt_clr_o (cnt_clr),
        .cnt_inc_o (cnt_inc),
        .phase_o   (phase),
        .cmd_o     (cmd_cur),
        .sample_o  (sample),
        .finish_o  (finish),
        .active_o  (active),
        .rd_n_o    (bus_rd_n_o),
        .wr_n_o    (bus_wr_n_o),
        .doe_o     (bus_doe_o)
    );

    pata_pio_addr_dec u_dec (
        .active_i (active),
        .reg_no_i (cmd_cur.reg_no),
        .cs_n_o   (bus_cs_n_o),
        .addr_o   (bus_addr_o)
    );

    // Sticky completion flag (set wins) and receive word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (finish) begin
                done_q <= 1'b1;
            end else if (done_clr_i) begin
                done_q <= 1'b0;
            end
            if (sample) begin
                rdata_q <= bus_din_i;
            end
        end
    end

    assign busy_o     = (phase != PH_IDLE);
    assign done_o     = done_q;
    assign rdata_o    = rdata_q;
    assign bus_dout_o = cmd_cur.wdata;

    AST_SELECT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n_o || !bus_wr_n_o) |-> (bus_cs_n_o != 2'b11)); // R2
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(busy_o) && !busy_o)); // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && pio_start_i) |=> (!busy_o || ($stable(bus_cs_n_o) && $stable(bus_addr_o)))); // R10
    AST_RDATA_ON_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_o) |-> ($past(!bus_rd_n_o) && bus_rd_n_o)); // R7

endmodule

// File: tb/pata_pio_engine_tb.sv
module pata_pio_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pio_start_i = 1'b0;
    logic        pio_wr_i = 1'b0;
    logic [3:0]  pio_reg_i = '0;
    logic [15:0] pio_wdata_i = '0;
    logic [7:0]  tim_setup_i = '0;
    logic [7:0]  tim_pulse_i = '0;
    logic [7:0]  tim_end_i = '0;
    logic [7:0]  tim_hold_i = '0;
    logic        rdy_en_i = 1'b0;
    logic        done_clr_i = 1'b0;
    logic        busy_o, done_o;
    logic [15:0] rdata_o;
    logic [1:0]  bus_cs_n_o;
    logic [2:0]  bus_addr_o;
    logic        bus_rd_n_o, bus_wr_n_o, bus_doe_o;
    logic [15:0] bus_dout_o;
    logic [15:0] bus_din_i = '0;
    logic        bus_rdy_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_rdata = '0;
    bit finished = 0;

    always #10 clk = ~clk;

    pata_pio_engine u_dut (
        .clk(clk), .rst_n(rst_n), .pio_start_i(pio_start_i), .pio_wr_i(pio_wr_i),
        .pio_reg_i(pio_reg_i), .pio_wdata_i(pio_wdata_i), .tim_setup_i(tim_setup_i),
        .tim_pulse_i(tim_pulse_i), .tim_end_i(tim_end_i), .tim_hold_i(tim_hold_i),
        .rdy_en_i(rdy_en_i), .done_clr_i(done_clr_i), .busy_o(busy_o), .done_o(done_o),
        .rdata_o(rdata_o), .bus_cs_n_o(bus_cs_n_o), .bus_addr_o(bus_addr_o),
        .bus_rd_n_o(bus_rd_n_o), .bus_wr_n_o(bus_wr_n_o), .bus_dout_o(bus_dout_o),
        .bus_doe_o(bus_doe_o), .bus_din_i(bus_din_i), .bus_rdy_i(bus_rdy_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One access; bench computes the expected phase of every cycle
    task automatic access(input bit wr, input int rg, input int wd, input int t1,
                          input int tw, input int t2, input int t4, input bit en,
                          input int stall, input int rv, input bit busy_start,
                          input bit clr_last);
        int l1, lw, lp, s, tot;
        logic [1:0] ecs;
        l1  = (t1 == 0) ? 1 : t1;
        lw  = (tw == 0) ? 1 : tw;
        lp  = (t2 > t4) ? t2 : t4;
        if (lp == 0) lp = 1;
        s   = en ? stall : 0;
        tot = l1 + lw + s + lp;
        ecs = rg[3] ? 2'b01 : 2'b10;
        @(negedge clk);
        pio_start_i = 1'b1; pio_wr_i = wr; pio_reg_i = rg[3:0]; pio_wdata_i = wd[15:0];
        tim_setup_i = t1[7:0]; tim_pulse_i = tw[7:0]; tim_end_i = t2[7:0];
        tim_hold_i = t4[7:0]; rdy_en_i = en;
        bus_din_i = ~rv[15:0]; bus_rdy_i = 1'b1;
        @(negedge clk);
        pio_start_i = 1'b0;
        for (int k = 1; k <= tot; k++) begin
            bit in_strb, exp_oe;
            int m;
            m = k - l1;
            in_strb = (m >= 1) && (m <= lw + s);
            exp_oe  = wr && (k <= l1 + lw + s + t4);
            chk(busy_o == 1'b1, "R11 busy", busy_o, 1);
            chk(bus_cs_n_o == ecs, "R2 cs", bus_cs_n_o, ecs);
            chk(bus_addr_o == rg[2:0], "R2 addr", bus_addr_o, rg[2:0]);
            chk(bus_rd_n_o == !(in_strb && !wr), "R3 R4 rd strobe", bus_rd_n_o, !(in_strb && !wr));
            chk(bus_wr_n_o == !(in_strb && wr), "R3 R4 wr strobe", bus_wr_n_o, !(in_strb && wr));
            chk(bus_doe_o == exp_oe, "R6 oe", bus_doe_o, exp_oe);
            if (exp_oe) chk(bus_dout_o == wd[15:0], "R6 dout", bus_dout_o, wd[15:0]);
            // stimulus for the edge that ends cycle k
            bus_din_i = in_strb ? rv[15:0] : ~rv[15:0];
            bus_rdy_i = !(in_strb && (stall > 0) && (m <= lw + stall - 1));
            if (busy_start && k == 2) begin
                pio_start_i = 1'b1; pio_wr_i = !wr; pio_reg_i = ~rg[3:0];
            end else begin
                pio_start_i = 1'b0; pio_wr_i = wr; pio_reg_i = rg[3:0];
            end
            done_clr_i = clr_last && (k == tot);
            @(negedge clk);
        end
        done_clr_i = 1'b0; bus_rdy_i = 1'b1;
        if (!wr) exp_rdata = rv[15:0];
        chk(busy_o == 1'b0, "R11 busy end", busy_o, 0);
        chk(done_o == 1'b1, "R8 R9 done set", done_o, 1);
        chk(rdata_o == exp_rdata, "R7 rdata", rdata_o, exp_rdata);
        chk(bus_cs_n_o == 2'b11, "R2 idle cs", bus_cs_n_o, 2'b11);
    endtask

    task automatic clear_done();
        @(negedge clk);
        done_clr_i = 1'b1;
        @(negedge clk);
        done_clr_i = 1'b0;
        chk(done_o == 1'b0, "R9 clear", done_o, 0);
    endtask

    initial begin
        int tv[3];
        int idx;
        idx = 0;
        tv = '{0, 1, 3};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy_o == 0 && done_o == 0, "R1 busy/done", {busy_o, done_o}, 0);
        chk(rdata_o == 0, "R1 rdata", rdata_o, 0);
        chk(bus_rd_n_o && bus_wr_n_o && bus_cs_n_o == 2'b11 && !bus_doe_o, "R1 bus idle",
            {bus_rd_n_o, bus_wr_n_o, bus_cs_n_o, bus_doe_o}, 5'b11110);
        rst_n = 1'b1;
        @(negedge clk);
        // Sweep of phase counts, both directions
        for (int d = 0; d < 2; d++)
            for (int a = 0; a < 3; a++)
                for (int b = 0; b < 3; b++)
                    for (int c = 0; c < 3; c++)
                        for (int e = 0; e < 3; e++) begin
                            access(d[0], idx % 16, 16'h1234 + idx * 97, tv[a], tv[b] + b,
                                   tv[c] + c, tv[e], 1'b0, 0, 16'hA500 + idx * 13, 1'b0, 1'b0);
                            clear_done();
                            idx++;
                        end
        // R5 ready stretching on and off
        access(1'b0, 5, 0, 1, 2, 2, 0, 1'b1, 3, 16'h5AA5, 1'b0, 1'b0);
        access(1'b1, 9, 16'hBEEF, 1, 2, 2, 1, 1'b1, 1, 0, 1'b0, 1'b0);
        access(1'b0, 3, 0, 2, 3, 1, 0, 1'b0, 4, 16'h0F0F, 1'b0, 1'b0);
        // R8 done stays set into next access; R9 set wins over clear on last edge
        access(1'b0, 12, 0, 3, 4, 5, 2, 1'b0, 0, 16'hC3C3, 1'b0, 1'b1);
        clear_done();
        // R10 start during busy ignored
        access(1'b1, 14, 16'h7E81, 3, 4, 5, 2, 1'b0, 0, 0, 1'b1, 1'b0);
        access(1'b0, 6, 0, 2, 3, 4, 0, 1'b0, 0, 16'h9966, 1'b1, 1'b0);
        clear_done();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule